// File: doc/BRIEF.md
# JTAG Master Host Register Unit

This block is the host-side register front of a JTAG test-bus master. It sits on an 8-bit host bus with an address, write data, read data, a read strobe, a write strobe and a ready line. Through that bus the host can read a live status byte, issue commands to the execution engine and poll them, load a 32-bit shift/loop counter one byte at a time, and drive the test-reset output.

The status byte shows four things: whether TDI data is waiting, whether the TDO buffer is full, whether the counter holds a complete value, and the TAP state the master is currently driving. A command write starts work in the engine, and the engine reports completion on `cmd_done`. While a command runs, the command register reads back the value that started it. Once the command completes, the opcode field falls back to the null code. Any other command write that arrives mid-command is held off by pulling ready low. A soft-reset write is never held off.

Top module: `jtm_host_regs`

Address map: 0 is status (read), 1 is command (read/write), 2 is the counter byte port (write). Unmapped reads, and any read without the strobe, return 0.

## Requirements
- R1: Status bit 7 is the inverse of `tdi_empty` and status bit 6 equals `tdo_full`. Both follow the inputs in the same cycle as the read, with no latching.
- R2: Status bits 3:0 carry `tap_state` unchanged (0000 Test-Logic-Reset through 1111 Update-IR, DR states 0000-0111, Run-Test/Idle 1000, IR states 1001-1111). Status bit 4 always reads 0.
- R3: Four accepted byte writes to address 2 fill `ctr_value` with the first byte in bits 7:0. Status bit 5 reads 1 from the cycle after the fourth byte. It reads 0 from the cycle after the first byte of any new load.
- R4: A command write accepted while idle stores bits 6:0 (bit 3:0 opcode, bit 6 reset level, bits 5:4 kept). When the stored opcode is non-zero, `cmd_start` pulses for exactly one cycle, on the cycle after acceptance.
- R5: While the opcode is non-zero, a command-register read and `cmd_opcode` return the stored value unchanged until `cmd_done`. Bit 7 always reads 0.
- R6: When `cmd_done` arrives during a command, the opcode bits 3:0 become 0000 on the next cycle. Bits 6:4 are kept.
- R7: A command write with bit 7 clear, arriving while a command runs, drives `host_rdy` low. If the strobe drops before `cmd_done`, the write has no effect.
- R8: A stalled command write still held when `cmd_done` arrives is accepted at that clock edge. `host_rdy` returns high on the following cycle.
- R9: A command write with bit 7 set is accepted at once, even mid-command, with `host_rdy` high. It clears the command register, the counter value and its loaded flag, and pulses `soft_rst` for one cycle.
- R10: `trst_out` equals `dc_trst` when `dc_mode` is 1, and equals stored command bit 6 otherwise.
- R11: A command whose opcode has bit 3 set (a counter command) that is written while status bit 5 is 0 is stored with opcode 0000 and raises no `cmd_start`.
- R12: Each assertion of `host_wr` performs at most one write, however many cycles it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, 0 when host_rd is low |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe, one write per assertion |
| host_rdy | output | 1 | Ready; low while a command write is stalled |
| tdi_empty | input | 1 | TDI read buffer empty |
| tdo_full | input | 1 | TDO write buffer full |
| tap_state | input | 4 | TAP state driven by the master |
| cmd_done | input | 1 | Engine reports command completion |
| cmd_start | output | 1 | One-cycle start pulse to the engine |
| cmd_opcode | output | 4 | Stored opcode |
| soft_rst | output | 1 | One-cycle soft reset pulse |
| ctr_value | output | 32 | Loaded counter value |
| dc_mode | input | 1 | Discrete-control mode select |
| dc_trst | input | 1 | Reset level used in discrete-control mode |
| trst_out | output | 1 | Test-reset output level |

## Verification
Read data, status bits and `host_rdy` depend on the current inputs and registered state alone, so they are due in the same cycle as the stimulus. The bench drives on the falling edge and samples 4 ns later, before the next rising edge. Register effects of an accepted write appear one rising edge later: the stored command, the counter bytes, the loaded flag, `cmd_start`, `soft_rst` and the opcode clear after `cmd_done`. A behavioural model updated on each rising edge predicts every output, and it is compared in that late-cycle window on every clock. Directed checks for the stall and late-accept cases sample in the exact cycle that R7 and R8 name.

// File: rtl/jtm_pkg.sv
package jtm_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned ADDR_STATUS = 0;
  localparam int unsigned ADDR_CMD    = 1;
  localparam int unsigned ADDR_CTR    = 2;
  localparam int unsigned SRST_BIT    = 7;
  localparam int unsigned TRST_BIT    = 6;
  localparam int unsigned OPC_W       = 4;
  localparam int unsigned CMD_W       = 7;
  localparam int unsigned CTR_OPC_BIT = 3;

  // live status byte: data waiting, tdo full, counter loaded, spare, tap state
  function automatic logic [BYTE_W-1:0] status_byte(input logic tdi_empty,
                                                    input logic tdo_full,
                                                    input logic loaded,
                                                    input logic [3:0] tap);
    return {~tdi_empty, tdo_full, loaded, 1'b0, tap};
  endfunction

  // counter commands are refused (turned to null) until the counter is loaded
  function automatic logic [OPC_W-1:0] admit_opcode(input logic [OPC_W-1:0] opc,
                                                   input logic loaded);
    return (opc[CTR_OPC_BIT] && !loaded) ? '0 : opc;
  endfunction
endpackage

// File: rtl/jtm_host_gate.sv
module jtm_host_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic host_wr,
  input  logic is_cmd,
  input  logic srst_req,
  input  logic busy,
  input  logic cmd_done,
  output logic wr_fire,
  output logic host_rdy
);
  logic taken_q;
  logic blocked;

  // a command write meets a running command and is not a soft reset
  assign blocked  = host_wr && is_cmd && !taken_q && busy && !srst_req;
  assign host_rdy = !blocked;
  // a held write goes through on the cycle the engine finishes
  assign wr_fire  = host_wr && !taken_q && (!blocked || cmd_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       taken_q <= 1'b0;
    else if (host_wr) taken_q <= taken_q | wr_fire;
    else              taken_q <= 1'b0;
  end

  p_one_write_per_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);
endmodule

// File: rtl/jtm_cmd_reg.sv
module jtm_cmd_reg
  import jtm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              cmd_done,
  input  logic              ctr_loaded,
  output logic [CMD_W-1:0]  cmd_q,
  output logic              busy,
  output logic              cmd_start,
  output logic              soft_rst,
  output logic              srst_now
);
  logic [OPC_W-1:0] opc_admit;
  logic             done_hit;

  assign busy      = cmd_q[OPC_W-1:0] != '0;
  assign srst_now  = cmd_fire && wdata[SRST_BIT];
  assign done_hit  = busy && cmd_done;
  assign opc_admit = admit_opcode(wdata[OPC_W-1:0], ctr_loaded);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      cmd_start <= 1'b0;
      soft_rst  <= 1'b0;
    end else begin
      cmd_start <= 1'b0;
      soft_rst  <= 1'b0;
      if (srst_now) begin
        cmd_q    <= '0;
        soft_rst <= 1'b1;
      end else if (cmd_fire) begin
        cmd_q     <= {wdata[CMD_W-1:OPC_W], opc_admit};
        cmd_start <= opc_admit != '0;
      end else if (done_hit) begin
        cmd_q[OPC_W-1:0] <= '0;
      end
    end
  end

  p_readback_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cmd_done && !cmd_fire |=> $stable(cmd_q));
  p_done_clears_opcode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit && !cmd_fire |=> cmd_q[OPC_W-1:0] == '0);
  p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);
  p_counter_cmd_refused_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && !ctr_loaded && wdata[CTR_OPC_BIT] |=> !cmd_start);
endmodule

// File: rtl/jtm_ctr_load.sv
module jtm_ctr_load
  import jtm_pkg::*;
#(
  parameter int unsigned BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_fire,
  input  logic                    clear,
  input  logic [BYTE_W-1:0]       wdata,
  output logic [BYTE_W*BYTES-1:0] value_q,
  output logic                    loaded_q
);
  localparam int unsigned IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTES - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      loaded_q <= 1'b0;
    end else if (clear) begin
      idx_q    <= '0;
      loaded_q <= 1'b0;
    end else if (wr_fire) begin
      idx_q    <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
      loaded_q <= (idx_q == LAST);
    end
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   value_q[BYTE_W*g +: BYTE_W] <= '0;
      else if (clear)                               value_q[BYTE_W*g +: BYTE_W] <= '0;
      else if (wr_fire && idx_q == IDX_W'(g))        value_q[BYTE_W*g +: BYTE_W] <= wdata;
    end
  end

  p_load_complete_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && !clear && idx_q == LAST |=> loaded_q);
  p_new_load_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && !clear && idx_q == '0 && BYTES > 1 |=> !loaded_q);
endmodule

// File: rtl/jtm_host_regs.sv
module jtm_host_regs
  import jtm_pkg::*;
#(
  parameter int unsigned AW        = 2,
  parameter int unsigned CTR_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [AW-1:0]               host_addr,
  input  logic [BYTE_W-1:0]           host_wdata,
  output logic [BYTE_W-1:0]           host_rdata,
  input  logic                        host_rd,
  input  logic                        host_wr,
  output logic                        host_rdy,
  input  logic                        tdi_empty,
  input  logic                        tdo_full,
  input  logic [3:0]                  tap_state,
  input  logic                        cmd_done,
  output logic                        cmd_start,
  output logic [OPC_W-1:0]            cmd_opcode,
  output logic                        soft_rst,
  output logic [BYTE_W*CTR_BYTES-1:0] ctr_value,
  input  logic                        dc_mode,
  input  logic                        dc_trst,
  output logic                        trst_out
);
  localparam logic [AW-1:0] LA_STATUS = AW'(ADDR_STATUS);
  localparam logic [AW-1:0] LA_CMD    = AW'(ADDR_CMD);
  localparam logic [AW-1:0] LA_CTR    = AW'(ADDR_CTR);

  logic              is_cmd, wr_fire, busy, srst_now, ctr_loaded;
  logic [CMD_W-1:0]  cmd_q;

  assign is_cmd = host_addr == LA_CMD;

  jtm_host_gate u_gate (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .is_cmd(is_cmd),
    .srst_req(host_wdata[SRST_BIT]), .busy(busy), .cmd_done(cmd_done),
    .wr_fire(wr_fire), .host_rdy(host_rdy));

  jtm_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_fire(wr_fire && is_cmd), .wdata(host_wdata),
    .cmd_done(cmd_done), .ctr_loaded(ctr_loaded), .cmd_q(cmd_q), .busy(busy),
    .cmd_start(cmd_start), .soft_rst(soft_rst), .srst_now(srst_now));

  jtm_ctr_load #(.BYTES(CTR_BYTES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire && host_addr == LA_CTR),
    .clear(srst_now), .wdata(host_wdata), .value_q(ctr_value), .loaded_q(ctr_loaded));

  assign cmd_opcode = cmd_q[OPC_W-1:0];
  assign trst_out   = dc_mode ? dc_trst : cmd_q[TRST_BIT];

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      if (host_addr == LA_STATUS)
        host_rdata = status_byte(tdi_empty, tdo_full, ctr_loaded, tap_state);
      else if (host_addr == LA_CMD)
        host_rdata = {1'b0, cmd_q};
    end
  end

  p_busy_write_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_wr) && is_cmd && !host_wdata[SRST_BIT] && busy |-> !host_rdy);
  p_soft_reset_immediate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_wr) && is_cmd && host_wdata[SRST_BIT] |=> soft_rst && cmd_opcode == '0);
  p_late_accept_rdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rdy && cmd_done |=> host_rdy || !host_wr);
  p_status_spare_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == LA_STATUS |-> host_rdata[4] == 1'b0);
endmodule

// File: tb/jtm_host_regs_bench.sv
module jtm_host_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_rd = 1'b0, host_wr = 1'b0, host_rdy;
  logic        tdi_empty = 1'b1, tdo_full = 1'b0;
  logic [3:0]  tap_state = '0;
  logic        cmd_done = 1'b0, cmd_start, soft_rst;
  logic [3:0]  cmd_opcode;
  logic [31:0] ctr_value;
  logic        dc_mode = 1'b0, dc_trst = 1'b0, trst_out;

  always #5 clk = ~clk;

  jtm_host_regs u_jtm_host_regs (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference
  logic [6:0]  m_cmd = '0;
  bit          m_taken = 0, m_loaded = 0, m_start = 0, m_srst = 0;
  int          m_bytes = 0;
  logic [31:0] m_ctr = '0;

  function automatic bit m_stalled();
    return host_wr && host_addr == 2'd1 && !m_taken && (m_cmd[3:0] != 0) && !host_wdata[7];
  endfunction

  always @(posedge clk) begin : model
    bit fire;
    logic [3:0] opc;
    if (!rst_n) begin
      m_cmd = '0; m_taken = 0; m_loaded = 0; m_start = 0; m_srst = 0; m_bytes = 0; m_ctr = '0;
    end else begin
      fire = host_wr && !m_taken && (!m_stalled() || cmd_done);
      m_start = 0; m_srst = 0;
      if (m_cmd[3:0] != 0 && cmd_done) m_cmd[3:0] = 4'd0;
      if (fire && host_addr == 2'd1) begin
        if (host_wdata[7]) begin
          m_cmd = '0; m_bytes = 0; m_loaded = 0; m_ctr = '0; m_srst = 1;
        end else begin
          opc = host_wdata[3:0];
          if (opc[3] && !m_loaded) opc = 4'd0;
          m_cmd = {host_wdata[6:4], opc};
          m_start = (opc != 0);
        end
      end
      if (fire && host_addr == 2'd2) begin
        m_ctr[8*m_bytes +: 8] = host_wdata;
        if (m_bytes == 0) m_loaded = 0;
        m_bytes++;
        if (m_bytes == 4) begin m_bytes = 0; m_loaded = 1; end
      end
      m_taken = host_wr ? (m_taken || fire) : 0;
    end
  end

  always @(negedge clk) begin
    logic [7:0] exp_rd;
    if (rst_n && !finished) begin
      #4;
      exp_rd = 8'h00;
      if (host_rd && host_addr == 2'd0)
        exp_rd = (tdi_empty ? 8'h00 : 8'h80) | (tdo_full ? 8'h40 : 8'h00) | (m_loaded ? 8'h20 : 8'h00) | {4'h0, tap_state};
      else if (host_rd && host_addr == 2'd1)
        exp_rd = {1'b0, m_cmd};
      chk(host_addr == 2'd0 ? "R1" : "R5", "rdata", host_rdata, exp_rd);
      chk("R7", "rdy", host_rdy, !m_stalled());
      chk("R5", "cmd_opcode", cmd_opcode, m_cmd[3:0]);
      chk("R4", "cmd_start", cmd_start, m_start);
      chk("R9", "soft_rst", soft_rst, m_srst);
      chk("R3", "ctr_value", ctr_value, m_ctr);
      chk("R10", "trst_out", trst_out, dc_mode ? dc_trst : m_cmd[6]);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input int hold);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    repeat (hold) @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 v = host_rdata;
    #5 host_rd = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); cmd_done = 1'b1;
    @(negedge clk); cmd_done = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd(2'd0, v); chk("R1", "reset status", v, 8'h00);
    rd(2'd1, v); chk("R5", "reset cmd", v, 8'h00);
    chk("R10", "reset trst", trst_out, 1'b0);
    // R1 R2: status follows inputs over every tap code
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      tap_state = 4'(k); tdi_empty = k[0]; tdo_full = k[1];
      rd(2'd0, v);
      chk("R2", "status tap", v, (k[0] ? 8'h00 : 8'h80) | (k[1] ? 8'h40 : 8'h00) | 8'(k));
    end
    tdi_empty = 1'b1; tdo_full = 1'b0; tap_state = 4'h8;
    // R3 counter load
    wr(2'd2, 8'h11, 1); wr(2'd2, 8'h22, 1); wr(2'd2, 8'h33, 1);
    rd(2'd0, v); chk("R3", "not yet loaded", v, 8'h08);
    wr(2'd2, 8'h44, 1);
    #1 chk("R3", "ctr value", ctr_value, 32'h44332211);
    rd(2'd0, v); chk("R3", "loaded status", v, 8'h28);
    // R4 start counter command
    wr(2'd1, 8'h49, 1);
    #1 chk("R4", "start pulse", cmd_start, 1'b1);
    chk("R10", "trst from cmd", trst_out, 1'b1);
    rd(2'd1, v); chk("R5", "readback", v, 8'h49);
    // R7 stall then abandon
    @(negedge clk); host_addr = 2'd1; host_wdata = 8'h02; host_wr = 1'b1;
    #1 chk("R7", "rdy low", host_rdy, 1'b0);
    repeat (2) @(negedge clk);
    #1 chk("R7", "rdy still low", host_rdy, 1'b0);
    @(negedge clk); host_wr = 1'b0;
    rd(2'd1, v); chk("R7", "abandoned write ignored", v, 8'h49);
    // R6 completion
    pulse_done();
    rd(2'd1, v); chk("R6", "opcode nulled", v, 8'h40);
    // R8 held write accepted at done
    wr(2'd1, 8'h45, 1);
    @(negedge clk); host_addr = 2'd1; host_wdata = 8'h06; host_wr = 1'b1;
    #1 chk("R8", "held rdy low", host_rdy, 1'b0);
    @(negedge clk); cmd_done = 1'b1;
    #1 chk("R8", "rdy low at done", host_rdy, 1'b0);
    @(negedge clk); cmd_done = 1'b0;
    #1 chk("R8", "rdy back", host_rdy, 1'b1);
    chk("R8", "start late", cmd_start, 1'b1);
    chk("R8", "opcode late", cmd_opcode, 4'h6);
    @(negedge clk); host_wr = 1'b0;
    rd(2'd1, v); chk("R8", "late readback", v, 8'h06);
    pulse_done();
    // R11 partial load refuses counter commands
    wr(2'd2, 8'h55, 1);
    rd(2'd0, v); chk("R3", "partial clears loaded", v, 8'h08);
    wr(2'd1, 8'h0A, 1);
    #1 chk("R11", "no start", cmd_start, 1'b0);
    rd(2'd1, v); chk("R11", "opcode null", v, 8'h00);
    // R9 soft reset mid-command
    wr(2'd1, 8'h43, 1);
    @(negedge clk); host_addr = 2'd1; host_wdata = 8'h80; host_wr = 1'b1;
    #1 chk("R9", "rdy during srst", host_rdy, 1'b1);
    @(negedge clk); host_wr = 1'b0;
    #1 chk("R9", "soft_rst pulse", soft_rst, 1'b1);
    chk("R9", "counter cleared", ctr_value, 32'h0);
    rd(2'd1, v); chk("R9", "cmd cleared", v, 8'h00);
    // R12 held counter write counts once
    wr(2'd2, 8'hAA, 3); wr(2'd2, 8'hBB, 1); wr(2'd2, 8'hCC, 1); wr(2'd2, 8'hDD, 1);
    #1 chk("R12", "single byte per strobe", ctr_value, 32'hDDCCBBAA);
    rd(2'd0, v); chk("R12", "loaded after four", v, 8'h28);
    // R10 discrete control
    wr(2'd1, 8'h40, 1);
    #1 chk("R10", "cmd level", trst_out, 1'b1);
    @(negedge clk); dc_mode = 1'b1; dc_trst = 1'b0;
    #1 chk("R10", "discrete low", trst_out, 1'b0);
    @(negedge clk); dc_trst = 1'b1;
    #1 chk("R10", "discrete high", trst_out, 1'b1);
    @(negedge clk); dc_mode = 1'b0; dc_trst = 1'b0;
    wr(2'd1, 8'h80, 1);
    #1 chk("R10", "after srst", trst_out, 1'b0);
    repeat (3) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule